// File: doc/BRIEF.md
# Command-Decoded Byte Memory

This block is a single-port byte store driven by a stream of 10-bit command words. Each word carries a 2-bit operation tag in its top bits and an 8-bit payload below. A tagged word either loads one of two independent address registers (one for writes, one for reads), stores the payload into the memory at the held write address, or fetches the byte at the held read address.

A fetch result appears on a registered byte output. It comes with a strobe that is high for exactly one cycle. Words are taken only while their valid strobe is high. The address registers persist between commands, so a host can set an address once and then issue several data or fetch words against it.

The memory is 256 bytes by default. Depth, address width and data width are parameters, and the command word is two bits wider than the data.

Top module: `cmd_mem`

## Requirements
- R1: While rst_ni is low, rd_byte_o and rd_vld_o are zero and both address registers are zero; a fetch issued right after reset reads address 0.
- R2: A word presented with cmd_vld_i low changes neither address register nor memory and produces no read strobe.
- R3: A valid word with tag 2'b00 (bits 9:8) loads bits 7:0 into the write-address register.
- R4: A valid word with tag 2'b01 stores bits 7:0 at the held write address; the write address is kept, so repeated data words overwrite the same location and the last one wins.
- R5: A valid word with tag 2'b10 loads bits 7:0 into the read-address register.
- R6: A valid word with tag 2'b11 puts the byte at the held read address on rd_byte_o at the next clock edge with rd_vld_o high, whatever bits 7:0 of that word hold.
- R7: rd_vld_o is high only in the cycle after a valid tag-11 word; after any other word or an idle cycle it is low, and rd_byte_o keeps its last value.
- R8: A fetch issued in the cycle right after a data word to the same address returns the new byte.
- R9: Loading either address register leaves the other one unchanged.
- R10: Memory contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_word_i | input | 10 | Command word: tag in bits 9:8, payload in bits 7:0 |
| cmd_vld_i | input | 1 | Qualifies cmd_word_i for the current cycle |
| rd_byte_o | output | 8 | Byte returned by the latest fetch |
| rd_vld_o | output | 1 | One-cycle strobe marking a new fetch result |

## Verification
The hardest case to reach from the ports is the point where the two address registers hold different values and a data word must land at the write address, not the read address. Only a later fetch shows where the byte went. The stimulus first fills every location with a computed pattern. It then loads the write address, loads a different read address, and sends invalid words with misleading tags. Fetches of both locations then show which one changed. A back-to-back data word and fetch covers the same-address forwarding case, and a reset between a write and a fetch shows that the data survives.

// File: rtl/cmd_mem_pkg.sv
package cmd_mem_pkg;

    typedef enum logic [1:0] {
        OP_SET_WADDR = 2'b00,
        OP_STORE     = 2'b01,
        OP_SET_RADDR = 2'b10,
        OP_FETCH     = 2'b11
    } op_e;

    localparam int unsigned NUM_OPS = 4;
    localparam int unsigned TAG_W   = 2;

endpackage

// File: rtl/cmd_mem_decode.sv
module cmd_mem_decode
    import cmd_mem_pkg::*;
#(
    parameter int unsigned DW = 8,
    localparam int unsigned CW = DW + TAG_W
) (
    input  logic [CW-1:0] word_i,
    input  logic          vld_i,
    output logic          set_waddr_o,
    output logic          store_o,
    output logic          set_raddr_o,
    output logic          fetch_o,
    output logic [DW-1:0] payload_o
);

    logic [TAG_W-1:0]   tag;
    logic [NUM_OPS-1:0] strobe;

    assign tag       = word_i[CW-1:DW];
    assign payload_o = word_i[DW-1:0];

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        assign strobe[i] = vld_i && (tag == TAG_W'(i));
    end

    assign set_waddr_o = strobe[OP_SET_WADDR];
    assign store_o     = strobe[OP_STORE];
    assign set_raddr_o = strobe[OP_SET_RADDR];
    assign fetch_o     = strobe[OP_FETCH];

endmodule

// File: rtl/cmd_mem_addr_regs.sv
module cmd_mem_addr_regs #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          set_waddr_i,
    input  logic          set_raddr_i,
    input  logic [DW-1:0] payload_i,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o
);

    typedef struct packed {
        logic [AW-1:0] waddr;
        logic [AW-1:0] raddr;
    } addr_state_t;

    addr_state_t   st_d, st_q;
    logic [AW-1:0] addr_in;

    if (AW <= DW) begin : g_slice
        assign addr_in = payload_i[AW-1:0];
    end else begin : g_extend
        assign addr_in = {{(AW-DW){1'b0}}, payload_i};
    end

    always_comb begin
        st_d = st_q;
        if (set_waddr_i) begin
            st_d.waddr = addr_in;
        end
        if (set_raddr_i) begin
            st_d.raddr = addr_in;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr_o = st_q.waddr;
    assign raddr_o = st_q.raddr;

endmodule

// File: rtl/cmd_mem_array.sv
module cmd_mem_array #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 8
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem [DEPTH];
    logic          w_in_range;
    logic          r_in_range;

    assign w_in_range = 32'(waddr_i) < DEPTH;
    assign r_in_range = 32'(raddr_i) < DEPTH;

    always_ff @(posedge clk_i) begin
        if (we_i && w_in_range) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = r_in_range ? mem[raddr_i] : '0;

endmodule

// File: rtl/cmd_mem.sv
module cmd_mem
    import cmd_mem_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned CW   = DW + TAG_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] cmd_word_i,
    input  logic          cmd_vld_i,
    output logic [DW-1:0] rd_byte_o,
    output logic          rd_vld_o
);

    typedef struct packed {
        logic [DW-1:0] rbyte;
        logic          rvld;
    } out_state_t;

    logic          set_waddr, store, set_raddr, fetch;
    logic [DW-1:0] payload;
    logic [AW-1:0] wr_addr_q, rd_addr_q;
    logic [DW-1:0] mem_rdata;
    out_state_t    out_d, out_q;

    cmd_mem_decode #(.DW(DW)) u_decode (
        .word_i      (cmd_word_i),
        .vld_i       (cmd_vld_i),
        .set_waddr_o (set_waddr),
        .store_o     (store),
        .set_raddr_o (set_raddr),
        .fetch_o     (fetch),
        .payload_o   (payload)
    );

    cmd_mem_addr_regs #(.AW(AW), .DW(DW)) u_addr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_waddr_i (set_waddr),
        .set_raddr_i (set_raddr),
        .payload_i   (payload),
        .waddr_o     (wr_addr_q),
        .raddr_o     (rd_addr_q)
    );

    cmd_mem_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_array (
        .clk_i   (clk_i),
        .we_i    (store),
        .waddr_i (wr_addr_q),
        .wdata_i (payload),
        .raddr_i (rd_addr_q),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        out_d      = out_q;
        out_d.rvld = fetch;
        if (fetch) begin
            out_d.rbyte = mem_rdata;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_byte_o = out_q.rbyte;
    assign rd_vld_o  = out_q.rvld;

endmodule

// File: rtl/cmd_mem_chk.sv
module cmd_mem_chk #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8,
    localparam int unsigned CW = DW + 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [CW-1:0] cmd_word_i,
    input logic          cmd_vld_i,
    input logic [DW-1:0] rd_byte_o,
    input logic          rd_vld_o,
    input logic [AW-1:0] wr_addr_q,
    input logic [AW-1:0] rd_addr_q
);

    logic [1:0] tag;
    assign tag = cmd_word_i[CW-1:CW-2];

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |=> (rd_vld_o == 1'b0 && rd_byte_o == '0 && wr_addr_q == '0 && rd_addr_q == '0)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_vld_i |=> (!rd_vld_o && $stable(wr_addr_q) && $stable(rd_addr_q))); // R2

    AST_WADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && tag == 2'b00) |=> (wr_addr_q == $past(cmd_word_i[AW-1:0]))); // R3

    AST_RADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && tag == 2'b10) |=> (rd_addr_q == $past(cmd_word_i[AW-1:0]))); // R5

    AST_FETCH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && tag == 2'b11) |=> rd_vld_o); // R6

    AST_NO_STRAY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cmd_vld_i && tag == 2'b11) |=> !rd_vld_o); // R7

    AST_BYTE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_vld_o |-> $stable(rd_byte_o)); // R7

    AST_WADDR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && tag != 2'b00) |=> $stable(wr_addr_q)); // R9

    AST_RADDR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && tag != 2'b10) |=> $stable(rd_addr_q)); // R9

endmodule

bind cmd_mem cmd_mem_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_word_i (cmd_word_i),
    .cmd_vld_i  (cmd_vld_i),
    .rd_byte_o  (rd_byte_o),
    .rd_vld_o   (rd_vld_o),
    .wr_addr_q  (wr_addr_q),
    .rd_addr_q  (rd_addr_q)
);

// File: tb/cmd_mem_tb_top.sv
module cmd_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [9:0] cmd_word_i = '0;
    logic       cmd_vld_i = 1'b0;
    logic [7:0] rd_byte_o;
    logic       rd_vld_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    cmd_mem dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cmd_word_i (cmd_word_i),
        .cmd_vld_i  (cmd_vld_i),
        .rd_byte_o  (rd_byte_o),
        .rd_vld_o   (rd_vld_o)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 73 + 29) & 255);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive one word at the falling edge, held across the next rising edge
    task automatic issue(logic [1:0] tag, logic [7:0] low, logic vld);
        @(negedge clk_i);
        cmd_word_i = {tag, low};
        cmd_vld_i  = vld;
        @(posedge clk_i);
    endtask

    // set the read address, fetch, and check the result one edge later
    task automatic fetch_check(string req, logic [7:0] addr, logic [7:0] junk, logic [7:0] exp);
        issue(2'b10, addr, 1'b1);
        issue(2'b11, junk, 1'b1);
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        check(req, int'(rd_vld_o), 1);
        check(req, int'(rd_byte_o), int'(exp));
    endtask

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk_i);
        // R1: outputs clear during reset
        check("R1", int'(rd_vld_o), 0);
        check("R1", int'(rd_byte_o), 0);
        rst_ni = 1'b1;

        // R3 R4: fill every location with the computed pattern
        for (int a = 0; a < DEPTH; a++) begin
            issue(2'b00, 8'(a), 1'b1);
            issue(2'b01, pat(a), 1'b1);
        end
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        check("R7", int'(rd_vld_o), 0);

        // R5 R6: read every location back, low byte of fetch word is junk
        for (int a = 0; a < DEPTH; a++) begin
            fetch_check("R6", 8'(a), 8'(~a), pat(a));
        end

        // R7: strobe lasts one cycle and byte is held across other words
        held = rd_byte_o;
        issue(2'b00, 8'h11, 1'b1);
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        check("R7", int'(rd_vld_o), 0);
        check("R7", int'(rd_byte_o), int'(held));
        issue(2'b10, 8'h22, 1'b1);
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        check("R7", int'(rd_vld_o), 0);
        check("R7", int'(rd_byte_o), int'(held));

        // R2: invalid words with every tag change nothing
        issue(2'b00, 8'd5, 1'b1);
        issue(2'b10, 8'd9, 1'b1);
        issue(2'b00, 8'd9, 1'b0);
        issue(2'b01, 8'hAA, 1'b0);
        issue(2'b10, 8'd5, 1'b0);
        issue(2'b11, 8'h00, 1'b0);
        @(negedge clk_i);
        check("R2", int'(rd_vld_o), 0);
        check("R2", int'(rd_byte_o), int'(held));
        // R9: write address still 5 while read address is 9
        issue(2'b01, 8'h3C, 1'b1);
        issue(2'b11, 8'hFF, 1'b1);
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        check("R9", int'(rd_vld_o), 1);
        check("R9", int'(rd_byte_o), int'(pat(9)));
        fetch_check("R9", 8'd5, 8'h00, 8'h3C);

        // R4: repeated data words to the held address, last one wins
        issue(2'b00, 8'd200, 1'b1);
        issue(2'b01, 8'h01, 1'b1);
        issue(2'b01, 8'h02, 1'b1);
        issue(2'b01, 8'hE7, 1'b1);
        fetch_check("R4", 8'd200, 8'h55, 8'hE7);
        fetch_check("R4", 8'd201, 8'h55, pat(201));

        // R8: data word then fetch in the very next cycle
        issue(2'b00, 8'd77, 1'b1);
        issue(2'b10, 8'd77, 1'b1);
        issue(2'b01, 8'h9D, 1'b1);
        issue(2'b11, 8'h00, 1'b1);
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        check("R8", int'(rd_vld_o), 1);
        check("R8", int'(rd_byte_o), 8'h9D);

        // R1 R10: reset clears outputs and addresses but not memory
        issue(2'b00, 8'd0, 1'b1);
        issue(2'b01, 8'hC4, 1'b1);
        issue(2'b00, 8'd40, 1'b1);
        issue(2'b10, 8'd40, 1'b1);
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1", int'(rd_vld_o), 0);
        check("R1", int'(rd_byte_o), 0);
        rst_ni = 1'b1;
        // fetch with no address load reads address 0
        issue(2'b11, 8'h33, 1'b1);
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
        check("R1", int'(rd_vld_o), 1);
        check("R1", int'(rd_byte_o), 8'hC4);
        // a store with no address load goes to address 0 as well
        issue(2'b01, 8'h6B, 1'b1);
        fetch_check("R1", 8'd0, 8'h00, 8'h6B);
        fetch_check("R10", 8'd40, 8'h00, pat(40));
        fetch_check("R10", 8'd255, 8'h00, pat(255));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule